// File: doc/BRIEF.md
# Magic-Sequence Watchdog Timer with Reset Cause

This block is a watchdog timer reached over a small 32-bit register bus. It counts rising edges of a slow watchdog clock, brought into the system clock domain through a short synchronizer. If the count reaches a power-of-two limit, it issues a one-cycle reset request. The limit is chosen by a 5-bit delay field.

Software keeps the timer alive with a two-step handshake. One fixed word goes to the first kick register, then a second fixed word goes to the second kick register. A wrong word, or a second-step write that no correct first step came before, is treated as a fault and also raises a reset request. Clearing the enable bit only asks for a stop. The counter halts when the next valid handshake completes. Software can also force a reset by writing the force register.

A three-bit cause code records why the last reset happened. Only the hard reset input clears it. A user reset input and every request the block raises itself overwrite it with their own code.

Top module: `kick_watchdog`

## Requirements
- R1: Offset 0x04 is the control register: bit 31 is the enable bit and bits [4:0] the delay value. Writes keep only those bits, and reads return them with every other bit zero.
- R2: While running, the block issues `rst_req` high for exactly one cycle after 2^(delay+1) synchronized rising edges of `wd_clk_in` without a valid handshake, and the cause becomes 1.
- R3: A valid handshake restarts the count from zero. The handshake is the word 0xABCD1234 written to offset 0x08, then 0x4321DCBA written to offset 0x0C.
- R4: While running, a wrong word written to 0x08 or 0x0C, or a write to 0x0C without a correct preceding write to 0x08, issues `rst_req` and sets the cause to 2.
- R5: While not running, writes to the kick registers raise no request and leave the cause unchanged.
- R6: Writing the enable bit as 0 while running does not stop the counter. The stop takes effect when the next valid handshake completes.
- R7: Writing offset 0x00 with bit 0 set issues `rst_req` and sets the cause to 3. With bit 0 clear the write has no effect.
- R8: Reading offset 0x08 returns the cause in bits [2:0] with bits [31:3] zero. The codes are 0 hard reset, 1 timeout, 2 bad handshake, 3 forced, 4 user reset. A request raised by the block does not clear the cause.
- R9: `rst_n` low at a clock edge clears the block and sets the cause to 0. `user_rst` high at an edge stops the counter, clears the control register and sets the cause to 4, without raising `rst_req`.
- R10: A new delay value written while running takes effect only at the next counter restart (start or valid handshake).
- R11: Reads of offsets 0x00, 0x0C and any unmapped offset return zero. Read data appears on `rdata` one cycle after `rd_en`.
- R12: Every request raised by the block stops the counter and clears the enable bit. The delay value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| user_rst | input | 1 | Synchronous user reset, records cause 4 |
| wd_clk_in | input | 1 | Slow watchdog clock, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with its defaults: a 5-bit delay, a two-stage synchronizer and an 8-bit offset. It drives a watchdog clock eight system cycles long. With delays of 2 and 5, the timeout spans 8 and 64 watchdog edges, which is a few hundred system cycles. At that scale the bench can watch the timeout, the keep-alive cadence, the deferred stop and the deferred delay change complete inside a short run. Timeout checks use windows wide enough to absorb the unknown phase between the watchdog clock and the write that starts the count.

// File: rtl/kwd_pkg.sv
// Package: shared constants and types for the kick watchdog.
// Assumes a 32-bit register bus with byte offsets.
package kwd_pkg;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_FORCE  = 8'h00;
    localparam logic [7:0] OFS_CTRL   = 8'h04;
    localparam logic [7:0] OFS_KICK_A = 8'h08;
    localparam logic [7:0] OFS_KICK_B = 8'h0C;

    localparam logic [DATA_W-1:0] MAGIC_A = 32'hABCD_1234;
    localparam logic [DATA_W-1:0] MAGIC_B = 32'h4321_DCBA;

    typedef enum logic [2:0] {
        CAUSE_HARD    = 3'd0,
        CAUSE_TIMEOUT = 3'd1,
        CAUSE_BADKICK = 3'd2,
        CAUSE_FORCED  = 3'd3,
        CAUSE_USER    = 3'd4
    } kwd_cause_e;
endpackage

// File: rtl/kwd_sync_tick.sv
// Module: brings the slow watchdog clock into the system domain and emits
// a one-cycle tick on each of its rising edges.
// Assumes the watchdog clock is much slower than clk.
module kwd_sync_tick #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic tick
);
    logic [STAGES:0] sh_q;

    // Synchronizer chain plus one extra flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign tick = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/kwd_counter.sv
// Module: power-of-two timeout counter. On reload it captures the delay
// and restarts at zero; it flags expiry on tick number 2^(delay+1).
// Assumes the caller clears run on expiry.
module kwd_counter #(
    parameter int DELAY_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reload,
    input  logic               run,
    input  logic               tick,
    input  logic [DELAY_W-1:0] delay_in,
    output logic               expire
);
    localparam int CNT_W = (1 << DELAY_W) + 1;

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   lim_m1;
    logic [CNT_W-1:0]   sh_amt;
    logic [DELAY_W-1:0] dly_q;

    // Last count value before expiry: delay+1 low ones.
    always_comb begin
        sh_amt = CNT_W'(dly_q) + CNT_W'(1);
        lim_m1 = ~({CNT_W{1'b1}} << sh_amt);
    end

    assign expire = run & tick & ~reload & (cnt_q == lim_m1);

    // Count ticks, restart on reload or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dly_q <= '0;
        end else if (reload) begin
            cnt_q <= '0;
            dly_q <= delay_in;
        end else if (expire) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R2: the count never passes the limit while running.
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim_m1));

    // R3: a reload leaves the count at zero.
    a_r3_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == '0));
endmodule

// File: rtl/kwd_kick_check.sv
// Module: checks the two-step keep-alive handshake. It arms on a correct
// first word and reports a good or a bad second step. Bad is reported
// only while running.
module kwd_kick_check
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              run,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    output logic              good,
    output logic              bad
);
    logic armed_q;
    logic a_ok;
    logic b_ok;

    // Classify the current kick write.
    always_comb begin
        a_ok = (wdata == MAGIC_A);
        b_ok = armed_q && (wdata == MAGIC_B);
        good = wr_b && b_ok;
        bad  = run && ((wr_a && !a_ok) || (wr_b && !b_ok));
    end

    // Track whether a correct first step is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) armed_q <= 1'b0;
        else if (wr_a)       armed_q <= a_ok;
        else if (wr_b)       armed_q <= 1'b0;
    end

    // R4: every second-step write consumes the armed state.
    a_r4_second_step_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> !armed_q);
endmodule

// File: rtl/kwd_cause_reg.sv
// Module: sticky last-reset cause. Only the hard reset clears it;
// otherwise it changes only when a new cause is presented.
module kwd_cause_reg
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  kwd_cause_e set_code,
    output kwd_cause_e cause
);
    kwd_cause_e cause_q;

    // Hold the most recent cause.
    always_ff @(posedge clk) begin
        if (!rst_n)      cause_q <= CAUSE_HARD;
        else if (set_en) cause_q <= set_code;
    end

    assign cause = cause_q;

    // R9: a hard reset edge leaves code 0.
    a_r9_hard_clears: assert property (@(posedge clk)
        !rst_n |=> (cause_q == CAUSE_HARD));

    // R8: only the defined codes are ever held.
    a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cause_q <= CAUSE_USER);
endmodule

// File: rtl/kick_watchdog.sv
// Module: top of the kick watchdog. Decodes the register bus and owns the
// control register and the running state. It ranks request sources as
// user reset > forced > bad handshake > timeout.
// Assumes at most one bus write per cycle and a slow wd_clk_in.
module kick_watchdog
    import kwd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DELAY_W     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_rst,
    input  logic              wd_clk_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    localparam int PAD_W = DATA_W - 1 - DELAY_W;

    logic               hit_force, hit_ctrl, hit_a, hit_b;
    logic               soft_fire, fire, start, reload;
    logic               tick, expire, tkl_good, tkl_bad;
    logic               cfg_en_q, run_q, rst_req_q;
    logic [DELAY_W-1:0] cfg_dly_q, dly_next;
    logic [DATA_W-1:0]  rdata_q;
    logic               cause_set;
    kwd_cause_e         cause_code, cause_now;

    // Address decode and request ranking.
    always_comb begin
        hit_force = wr_en && (addr == ADDR_W'(OFS_FORCE));
        hit_ctrl  = wr_en && (addr == ADDR_W'(OFS_CTRL));
        hit_a     = wr_en && (addr == ADDR_W'(OFS_KICK_A));
        hit_b     = wr_en && (addr == ADDR_W'(OFS_KICK_B));
        soft_fire = hit_force && wdata[0];
        fire      = !user_rst && (soft_fire || tkl_bad || expire);
        start     = hit_ctrl && wdata[DATA_W-1] && !run_q;
        reload    = start || (tkl_good && run_q);
        dly_next  = hit_ctrl ? wdata[DELAY_W-1:0] : cfg_dly_q;
        cause_set = user_rst || fire;
        if (user_rst)       cause_code = CAUSE_USER;
        else if (soft_fire) cause_code = CAUSE_FORCED;
        else if (tkl_bad)   cause_code = CAUSE_BADKICK;
        else                cause_code = CAUSE_TIMEOUT;
    end

    kwd_sync_tick #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(wd_clk_in), .tick(tick)
    );

    kwd_counter #(.DELAY_W(DELAY_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .reload(reload), .run(run_q),
        .tick(tick), .delay_in(dly_next), .expire(expire)
    );

    kwd_kick_check kick_i (
        .clk(clk), .rst_n(rst_n), .flush(fire || user_rst), .run(run_q),
        .wr_a(hit_a), .wr_b(hit_b), .wdata(wdata),
        .good(tkl_good), .bad(tkl_bad)
    );

    kwd_cause_reg cause_i (
        .clk(clk), .rst_n(rst_n), .set_en(cause_set),
        .set_code(cause_code), .cause(cause_now)
    );

    // Control register, running state and the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || user_rst) begin
            cfg_en_q  <= 1'b0;
            cfg_dly_q <= '0;
            run_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= fire;
            if (hit_ctrl) begin
                cfg_en_q  <= wdata[DATA_W-1];
                cfg_dly_q <= wdata[DELAY_W-1:0];
            end
            if (fire) begin
                cfg_en_q <= 1'b0;
                run_q    <= 1'b0;
            end else if (start) begin
                run_q <= 1'b1;
            end else if (tkl_good && run_q && !cfg_en_q) begin
                run_q <= 1'b0;
            end
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            if (addr == ADDR_W'(OFS_CTRL))
                rdata_q <= {cfg_en_q, {PAD_W{1'b0}}, cfg_dly_q};
            else if (addr == ADDR_W'(OFS_KICK_A))
                rdata_q <= {{(DATA_W-3){1'b0}}, cause_now};
            else
                rdata_q <= '0;
        end
    end

    assign rdata   = rdata_q;
    assign rst_req = rst_req_q;

    // R6: the counter stops only after a handshake, a request or a user reset.
    a_r6_stop_needs_kick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(tkl_good || fire || user_rst));

    // R12: a request leaves the block stopped and disabled.
    a_r12_req_stops: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_q |-> (!run_q && !cfg_en_q));
endmodule

// File: tb/kick_watchdog_tb_top.sv
module kick_watchdog_tb_top;
    localparam logic [31:0] MA = 32'hABCD_1234;
    localparam logic [31:0] MB = 32'h4321_DCBA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user_rst = 1'b0;
    logic        wd_clk_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int tests = 0;
    int fails = 0;
    int req_cnt = 0;
    logic rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;
    always #16 wd_clk_in = ~wd_clk_in;

    kick_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .user_rst(user_rst), .wd_clk_in(wd_clk_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rst_req(rst_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: count request pulses and score reads.
    always @(posedge clk) rd_d <= rd_en;
    always @(negedge clk) begin
        if (rst_req) req_cnt++;
        if (rd_d) begin
            if (exp_q.size() == 0) chk(0, "scoreboard empty", rdata, 0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata === e, t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic kick();
        wr(8'h08, MA);
        wr(8'h0C, MB);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_req(input int base, input int delta, input string t);
        chk(req_cnt == base + delta, t, req_cnt - base, delta);
    endtask

    initial begin
        int base;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        // R9 / R8: reset state
        chk(rst_req == 1'b0, "R9 no request after reset", rst_req, 0);
        rd(8'h08, 32'h0, "R8 cause after hard reset");
        rd(8'h04, 32'h0, "R1 control after reset");
        // R1: only bit 31 and [4:0] are kept
        wr(8'h04, 32'h7FFF_FFE3);
        rd(8'h04, 32'h0000_0003, "R1 masked control");
        // R11: unmapped and write-only offsets read zero
        rd(8'h00, 32'h0, "R11 force reads zero");
        rd(8'h0C, 32'h0, "R11 second kick reads zero");
        rd(8'h10, 32'h0, "R11 unmapped reads zero");
        // R2: timeout after 8 edges with delay 2
        base = req_cnt;
        wr(8'h04, 32'h8000_0002);
        wait_cyc(48);
        chk_req(base, 0, "R2 no early timeout");
        wait_cyc(60);
        chk_req(base, 1, "R2 one timeout request");
        rd(8'h08, 32'h1, "R2 cause timeout");
        rd(8'h04, 32'h0000_0002, "R12 enable cleared, delay kept");
        wait_cyc(100);
        chk_req(base, 1, "R12 no repeat after request");
        // R3: regular handshakes keep it alive
        base = req_cnt;
        wr(8'h04, 32'h8000_0002);
        for (int i = 0; i < 10; i++) begin
            wait_cyc(30);
            kick();
        end
        chk_req(base, 0, "R3 handshakes prevent timeout");
        // R6: clearing enable alone does not stop
        wr(8'h04, 32'h0000_0002);
        wait_cyc(110);
        chk_req(base, 1, "R6 still times out without handshake");
        // R6: clear enable then handshake stops
        base = req_cnt;
        wr(8'h04, 32'h8000_0002);
        wait_cyc(20);
        wr(8'h04, 32'h0000_0002);
        kick();
        wait_cyc(250);
        chk_req(base, 0, "R6 stopped after handshake");
        // R4: wrong first word while running
        base = req_cnt;
        wr(8'h04, 32'h8000_0002);
        wr(8'h08, 32'h1111_2222);
        wait_cyc(2);
        chk_req(base, 1, "R4 wrong first word");
        rd(8'h08, 32'h2, "R4 cause bad handshake");
        // R4: second step without first
        wr(8'h04, 32'h0000_0000);
        rd(8'h08, 32'h2, "R8 cause kept over control write");
        base = req_cnt;
        wr(8'h04, 32'h8000_0002);
        wr(8'h0C, MB);
        wait_cyc(2);
        chk_req(base, 1, "R4 second step without first");
        // R5: kicks ignored while stopped
        wr(8'h00, 32'h1);
        wait_cyc(2);
        rd(8'h08, 32'h3, "R7 cause forced");
        base = req_cnt;
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h0);
        wait_cyc(2);
        chk_req(base, 0, "R5 no request while stopped");
        rd(8'h08, 32'h3, "R5 cause unchanged while stopped");
        // R7: force with bit 0 clear has no effect
        base = req_cnt;
        wr(8'h00, 32'hFFFF_FFFE);
        wait_cyc(2);
        chk_req(base, 0, "R7 bit0 clear ignored");
        // R10: delay change waits for restart
        base = req_cnt;
        wr(8'h04, 32'h8000_0002);
        wr(8'h04, 32'h8000_0005);
        wait_cyc(108);
        chk_req(base, 1, "R10 old delay still used");
        base = req_cnt;
        wr(8'h04, 32'h8000_0002);
        wait_cyc(20);
        wr(8'h04, 32'h8000_0005);
        kick();
        wait_cyc(400);
        chk_req(base, 0, "R10 new delay after handshake");
        wait_cyc(200);
        chk_req(base, 1, "R10 long timeout expires");
        // R9: user reset
        wr(8'h04, 32'h8000_0004);
        @(negedge clk); user_rst = 1'b1;
        @(negedge clk); user_rst = 1'b0;
        rd(8'h08, 32'h4, "R9 user reset cause");
        rd(8'h04, 32'h0, "R9 user reset clears control");
        // R9: hard reset
        @(negedge clk); rst_n = 1'b0;
        wait_cyc(2); rst_n = 1'b1;
        wait_cyc(2);
        rd(8'h08, 32'h0, "R9 hard reset cause");
        wait_cyc(3);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #600000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule